// File: doc/BRIEF.md
# Node Error Confinement and Redundant Bus Failover

This block sits beside one node of a time-scheduled field bus. It keeps two saturating up/down error counters, one for frames the node sends and one for frames it receives. From these counters it derives the node's confinement state: active, passive or bus-off. It also steers the node's outgoing traffic between a main bus and a spare bus.

The frame engine reports each finished transfer with one of four single-cycle strobes: send success, send failure, receive success or receive failure. It also pulses a strobe at the start of every schedule cycle. The block answers with four things:
- the confinement state;
- whether the node may raise an error flag;
- which bus the next send attempt uses;
- whether the pending message is waiting for a retry.

It also issues a one-cycle discard pulse that tells the message store to drop the pending message.

The failover policy works in two stages. The first failed send keeps the message pending and moves its retry to the spare bus. A second failed send while on the spare bus drops the message and moves the node back to the main bus. A node in bus-off has its pending message purged at every cycle start, so it never gets to send.

The design is built from three state machines:
- The counter pair.
- The confinement machine, with states CONF_ACTIVE, CONF_PASSIVE and CONF_BUSOFF. Its named transitions are ACT_TO_PAS, ACT_TO_OFF, PAS_TO_ACT, PAS_TO_OFF, OFF_TO_PAS and OFF_TO_ACT.
- The lane machine, with states LANE_MAIN and LANE_SPARE. Its named transitions are MAIN_FAIL (LANE_MAIN to LANE_SPARE) and SPARE_FAIL (LANE_SPARE to LANE_MAIN).

Top module: `node_fault_guard`

## Requirements
- R1: After reset the state is active (code 0), the error flag is permitted, the main bus (bus_sel_o = 0) is selected, and retry_o and discard_o are low.
- R2: A send failure raises the send counter by one, and a receive failure raises the receive counter by one. Each counter holds at its maximum, 2^CNT_W-1 (15 by default), instead of wrapping.
- R3: A send success lowers the send counter by one, and a receive success lowers the receive counter by one. A success that arrives while the counter is zero leaves it at zero.
- R4: err_state_o is 2 (bus-off) when the send counter is at least BUSOFF_LIM (8). Otherwise it is 1 (passive) when either counter is at least PASSIVE_LIM (4). Otherwise it is 0 (active). The state follows the counters one clock edge after they change.
- R5: A cycle-start strobe while the state is bus-off produces a one-cycle discard pulse and clears retry_o. In any other state, a cycle-start strobe does neither.
- R6: After a send failure that does not drop the message, the message stays pending and retry_o goes high.
- R7: A send failure while the main bus is selected switches bus_sel_o to 1 (spare) and raises no discard pulse.
- R8: A send failure while the spare bus is selected switches bus_sel_o back to 0 (main), pulses discard_o high for exactly one cycle, and clears retry_o.
- R9: A send success clears retry_o and leaves bus_sel_o unchanged.
- R10: err_flag_ok_o is high only while the state is active (code 0).
- R11: When a success strobe and a failure strobe for the same counter arrive together, the failure takes effect and the counter rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start_i | input | 1 | Schedule cycle start strobe |
| tx_ok_i | input | 1 | Own frame sent without error |
| tx_err_i | input | 1 | Own frame send failed |
| rx_ok_i | input | 1 | Frame received without error |
| rx_err_i | input | 1 | Frame reception failed |
| err_state_o | output | 2 | Confinement state: 0 active, 1 passive, 2 bus-off |
| err_flag_ok_o | output | 1 | Node may signal an error flag |
| bus_sel_o | output | 1 | Bus for the next send: 0 main, 1 spare |
| retry_o | output | 1 | Failed message pending for retry |
| discard_o | output | 1 | One-cycle pulse: drop the pending message |

## Verification
Strobes are sampled on a rising edge. bus_sel_o, retry_o and discard_o all change on that same edge. err_state_o and err_flag_ok_o settle one edge later, because the counters register first and the confinement machine registers from them. The bench drives each strobe for exactly one cycle on a falling edge. It reads the lane outputs at the next falling edge. It reads the state only after one further idle cycle, and that same idle cycle also shows that the discard pulse has ended. Counter values are observed only through the state thresholds, so floor and saturation are checked by counting how many opposite strobes it takes to cross a threshold.

// File: rtl/nfg_pkg.sv
package nfg_pkg;

    typedef enum logic [1:0] {
        CONF_ACTIVE  = 2'd0,
        CONF_PASSIVE = 2'd1,
        CONF_BUSOFF  = 2'd2
    } conf_e;

    typedef enum logic {
        LANE_MAIN  = 1'b0,
        LANE_SPARE = 1'b1
    } lane_e;

endpackage

// File: rtl/nfg_err_counter.sv
module nfg_err_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // failure wins over a simultaneous success
    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) begin
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
        end else if (dec_i) begin
            if (cnt_q != '0) cnt_d = cnt_q - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CNT_ONE) || (cnt_q == $past(cnt_q) - CNT_ONE))); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R2
    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && cnt_q == '0) |=> (cnt_q == '0)); // R3
    AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R11

endmodule

// File: rtl/nfg_conf_fsm.sv
module nfg_conf_fsm
    import nfg_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int PASSIVE_LIM = 4,
    parameter int BUSOFF_LIM  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    output conf_e            state_o,
    output logic             flag_ok_o
);
    localparam logic [CNT_W-1:0] P_LIM = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] B_LIM = CNT_W'(BUSOFF_LIM);

    conf_e state_q;
    conf_e state_d;
    logic  want_off;
    logic  want_pas;

    assign want_off = (tx_cnt_i >= B_LIM);
    assign want_pas = (tx_cnt_i >= P_LIM) || (rx_cnt_i >= P_LIM);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CONF_ACTIVE: begin
                if (want_off)      state_d = CONF_BUSOFF;   // ACT_TO_OFF
                else if (want_pas) state_d = CONF_PASSIVE;  // ACT_TO_PAS
            end
            CONF_PASSIVE: begin
                if (want_off)      state_d = CONF_BUSOFF;   // PAS_TO_OFF
                else if (!want_pas) state_d = CONF_ACTIVE;  // PAS_TO_ACT
            end
            CONF_BUSOFF: begin
                if (!want_off) begin
                    if (want_pas) state_d = CONF_PASSIVE;   // OFF_TO_PAS
                    else          state_d = CONF_ACTIVE;    // OFF_TO_ACT
                end
            end
            default: state_d = CONF_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CONF_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o   = state_q;
        flag_ok_o = (state_q == CONF_ACTIVE);
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != conf_e'(2'd3))); // R4
    AST_OFF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt_i >= B_LIM) |=> (state_q == CONF_BUSOFF)); // R4
    AST_CLEAN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt_i < P_LIM && rx_cnt_i < P_LIM) |=> (state_q == CONF_ACTIVE)); // R4

endmodule

// File: rtl/nfg_lane_fsm.sv
module nfg_lane_fsm
    import nfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_ok_i,
    input  logic tx_err_i,
    input  logic cyc_start_i,
    input  logic busoff_i,
    output logic lane_o,
    output logic retry_o,
    output logic discard_o
);
    lane_e lane_q;
    lane_e lane_d;
    logic  purge;

    assign purge = cyc_start_i && busoff_i;

    always_comb begin
        lane_d = lane_q;
        unique case (lane_q)
            LANE_MAIN:  if (tx_err_i) lane_d = LANE_SPARE;  // MAIN_FAIL
            LANE_SPARE: if (tx_err_i) lane_d = LANE_MAIN;   // SPARE_FAIL
            default:    lane_d = LANE_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= LANE_MAIN;
        else        lane_q <= lane_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            retry_o   <= 1'b0;
            discard_o <= 1'b0;
        end else begin
            discard_o <= purge || (tx_err_i && lane_q == LANE_SPARE);
            if (purge)         retry_o <= 1'b0;
            else if (tx_err_i) retry_o <= (lane_q == LANE_MAIN);
            else if (tx_ok_i)  retry_o <= 1'b0;
        end
    end

    assign lane_o = lane_q;

    AST_MAIN_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_i && lane_q == LANE_MAIN && !purge) |=> (lane_q == LANE_SPARE && retry_o && !discard_o)); // R7
    AST_SPARE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_i && lane_q == LANE_SPARE) |=> (lane_q == LANE_MAIN && discard_o && !retry_o)); // R8
    AST_PURGE: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> (discard_o && !retry_o)); // R5
    AST_OK_HOLDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ok_i && !tx_err_i) |=> (lane_q == $past(lane_q) && !retry_o)); // R9

endmodule

// File: rtl/node_fault_guard.sv
module node_fault_guard
    import nfg_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int PASSIVE_LIM = 4,
    parameter int BUSOFF_LIM  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start_i,
    input  logic       tx_ok_i,
    input  logic       tx_err_i,
    input  logic       rx_ok_i,
    input  logic       rx_err_i,
    output logic [1:0] err_state_o,
    output logic       err_flag_ok_o,
    output logic       bus_sel_o,
    output logic       retry_o,
    output logic       discard_o
);
    localparam int N_CNT  = 2;
    localparam int IDX_TX = 0;
    localparam int IDX_RX = 1;

    logic [N_CNT-1:0] inc_v;
    logic [N_CNT-1:0] dec_v;
    logic [CNT_W-1:0] cnt_v [N_CNT];
    conf_e            conf_state;

    assign inc_v[IDX_TX] = tx_err_i;
    assign dec_v[IDX_TX] = tx_ok_i;
    assign inc_v[IDX_RX] = rx_err_i;
    assign dec_v[IDX_RX] = rx_ok_i;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        nfg_err_counter #(.CNT_W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (inc_v[g]),
            .dec_i (dec_v[g]),
            .cnt_o (cnt_v[g])
        );
    end

    nfg_conf_fsm #(
        .CNT_W       (CNT_W),
        .PASSIVE_LIM (PASSIVE_LIM),
        .BUSOFF_LIM  (BUSOFF_LIM)
    ) i_conf (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_cnt_i  (cnt_v[IDX_TX]),
        .rx_cnt_i  (cnt_v[IDX_RX]),
        .state_o   (conf_state),
        .flag_ok_o (err_flag_ok_o)
    );

    nfg_lane_fsm i_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_ok_i     (tx_ok_i),
        .tx_err_i    (tx_err_i),
        .cyc_start_i (cyc_start_i),
        .busoff_i    (conf_state == CONF_BUSOFF),
        .lane_o      (bus_sel_o),
        .retry_o     (retry_o),
        .discard_o   (discard_o)
    );

    assign err_state_o = conf_state;

    AST_NO_PURGE_UNLESS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start_i && !tx_err_i && conf_state != CONF_BUSOFF) |=> !discard_o); // R5
    AST_FLAG_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_state_o != 2'd0) |-> !err_flag_ok_o); // R10

endmodule

// File: tb/test_node_fault_guard.sv
`timescale 1ns/1ps
module test_node_fault_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start_i = 1'b0;
    logic       tx_ok_i = 1'b0;
    logic       tx_err_i = 1'b0;
    logic       rx_ok_i = 1'b0;
    logic       rx_err_i = 1'b0;
    logic [1:0] err_state_o;
    logic       err_flag_ok_o;
    logic       bus_sel_o;
    logic       retry_o;
    logic       discard_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    node_fault_guard i_node_fault_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .cyc_start_i   (cyc_start_i),
        .tx_ok_i       (tx_ok_i),
        .tx_err_i      (tx_err_i),
        .rx_ok_i       (rx_ok_i),
        .rx_err_i      (rx_err_i),
        .err_state_o   (err_state_o),
        .err_flag_ok_o (err_flag_ok_o),
        .bus_sel_o     (bus_sel_o),
        .retry_o       (retry_o),
        .discard_o     (discard_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic cs, input logic txo, input logic txe,
                         input logic rxo, input logic rxe);
        cyc_start_i = cs; tx_ok_i = txo; tx_err_i = txe; rx_ok_i = rxo; rx_err_i = rxe;
        @(negedge clk);
        cyc_start_i = 0; tx_ok_i = 0; tx_err_i = 0; rx_ok_i = 0; rx_err_i = 0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 state", err_state_o, 0);
        check("R1 bus", bus_sel_o, 0);
        check("R1 retry", retry_o, 0);
        check("R1 discard", discard_o, 0);
        check("R10 flag at reset", err_flag_ok_o, 1);
        pulse(1, 0, 0, 0, 0);
        check("R5 no discard when active", discard_o, 0);
    endtask

    task automatic t_rx_limits();
        repeat (4) pulse(0, 0, 0, 0, 1);
        settle();
        check("R4 passive at rec 4", err_state_o, 1);
        check("R10 flag off in passive", err_flag_ok_o, 0);
        pulse(0, 0, 0, 1, 0);
        settle();
        check("R3 active after one success", err_state_o, 0);
        check("R10 flag back on", err_flag_ok_o, 1);
        repeat (5) pulse(0, 0, 0, 1, 0);   // 3 to zero, 2 extra
        repeat (3) pulse(0, 0, 0, 0, 1);
        settle();
        check("R3 floor at zero, still active", err_state_o, 0);
        pulse(0, 0, 0, 0, 1);
        settle();
        check("R2 fourth failure passive", err_state_o, 1);
        repeat (4) pulse(0, 0, 0, 1, 0);
        settle();
    endtask

    task automatic t_saturate();
        repeat (20) pulse(0, 0, 0, 0, 1);
        repeat (11) pulse(0, 0, 0, 1, 0);
        settle();
        check("R2 saturated, 11 down still passive", err_state_o, 1);
        pulse(0, 0, 0, 1, 0);
        settle();
        check("R2 saturated, 12 down active", err_state_o, 0);
        repeat (3) pulse(0, 0, 0, 1, 0);
    endtask

    task automatic t_simultaneous();
        repeat (4) pulse(0, 0, 0, 1, 1);
        settle();
        check("R11 failure wins", err_state_o, 1);
        repeat (4) pulse(0, 0, 0, 1, 0);
        settle();
        check("R11 cleanup active", err_state_o, 0);
    endtask

    task automatic t_lane();
        pulse(0, 0, 1, 0, 0);
        check("R7 bus to spare", bus_sel_o, 1);
        check("R6 retry pending", retry_o, 1);
        check("R7 no discard", discard_o, 0);
        pulse(0, 0, 1, 0, 0);
        check("R8 bus to main", bus_sel_o, 0);
        check("R8 discard pulse", discard_o, 1);
        check("R8 retry cleared", retry_o, 0);
        settle();
        check("R8 discard one cycle", discard_o, 0);
        pulse(0, 0, 1, 0, 0);
        pulse(0, 1, 0, 0, 0);
        check("R9 retry cleared on success", retry_o, 0);
        check("R9 bus kept", bus_sel_o, 1);
        pulse(0, 0, 1, 0, 0);
        check("R8 second failure drops", discard_o, 1);
        repeat (3) pulse(0, 1, 0, 0, 0);
        settle();
        check("R3 tx back to active", err_state_o, 0);
    endtask

    task automatic t_busoff();
        repeat (4) pulse(0, 0, 1, 0, 0);
        settle();
        check("R4 passive at tec 4", err_state_o, 1);
        repeat (5) pulse(0, 0, 1, 0, 0);
        settle();
        check("R4 bus-off at tec 9", err_state_o, 2);
        check("R10 flag off in bus-off", err_flag_ok_o, 0);
        check("R6 retry before purge", retry_o, 1);
        pulse(1, 0, 0, 0, 0);
        check("R5 purge discard", discard_o, 1);
        check("R5 purge clears retry", retry_o, 0);
    endtask

    initial begin
        t_reset();
        t_rx_limits();
        t_saturate();
        t_simultaneous();
        t_lane();
        t_busoff();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule